// File: doc/BRIEF.md
# SPI Flash Page Program Sequencer

This block runs the page-program command path of a serial flash slave. The bit shifter in front of it delivers whole bytes, one pulse for each chip-select edge, and a count of the bits latched in the byte now arriving. The sequencer parses the opcode and a 24-bit address. It collects the data bytes into a one-page buffer that keeps a valid flag for each byte. When chip select rises, it decides whether the command may run.

If the command is accepted, the block raises a busy flag for a fixed number of cycles and pulses a request to clear the write-enable latch. When the busy time ends, it merges the buffered bytes into a small array model. The merge can only clear bits. The write-enable state and the block-protect level come from the status register, which lives outside this block. A read port exposes the array.

Top module: `pp_seq`

## Requirements
- R1: A command is a `cs_fall_i` pulse, then the opcode byte 0x02, then three address bytes with the most significant byte first, then data bytes. Only the low `ADDR_W` address bits are used. The page is the address bits above bit `PAGE_W-1`.
- R2: A programmed array byte becomes the old value ANDed with the data byte, so bits only go from 1 to 0.
- R3: The command is ignored when `wel_i` is low at the opcode byte or at the `cs_rise_i` pulse.
- R4: When more than 2^`PAGE_W` data bytes are sent, the write position wraps inside the page, starting from the address offset. Only the most recent byte for each offset is programmed.
- R5: With fewer data bytes, each byte goes to its own address in order from the start offset. Array bytes the command did not write stay unchanged.
- R6: The command is dropped when `cs_rise_i` comes with `bit_cnt_i` not 0. It is also dropped when no full data byte was received.
- R7: `wip_o` is high for exactly `PROG_CYCLES` cycles, starting the cycle after the accepted `cs_rise_i`. The array shows the new data once `wip_o` is low.
- R8: `wel_clr_o` pulses for one cycle, in the first `wip_o` cycle of each executed command. It does not pulse otherwise.
- R9: The protect level k = `bp_i` protects the top min(2^(k-1), page count) pages when k > 0. A command aimed at a protected page is not executed.
- R10: A command whose opcode arrives while `wip_o` is high is ignored.
- R11: After reset, `wip_o` and `wel_clr_o` are 0 and every array byte reads 0xFF.
- R12: Any opcode other than 0x02 makes the block ignore the rest of that chip-select period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_fall_i | input | 1 | Chip select went active (one-cycle pulse) |
| cs_rise_i | input | 1 | Chip select went inactive (one-cycle pulse) |
| bit_cnt_i | input | 3 | Bits latched in the current byte when chip select rises |
| byte_valid_i | input | 1 | A full byte is present on `byte_i` |
| byte_i | input | 8 | Deserialized byte |
| wel_i | input | 1 | Write-enable latch from the status register |
| bp_i | input | 3 | Block-protect level from the status register |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array byte at `rd_addr_i` |
| wip_o | output | 1 | Program in progress |
| wel_clr_o | output | 1 | Request to clear the write-enable latch |

## Verification
The bench sends over 256 data bytes from a mid-page offset. A design that did not wrap would spill into the next page or keep the first bytes instead of the last. It raises chip select partway through a byte, and also straight after the address. A design that ignored the bit count or the data-seen condition would program garbage in those cases. It starts a second command while the first is still busy, repeats a program to the same address, and targets pages just inside and just outside the protected range. These cases expose a block that accepts commands while busy, overwrites bytes instead of ANDing them, or gets the protect boundary wrong by one page.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam logic [7:0] OPC_PROG = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } pp_state_e;
endpackage

// File: rtl/pp_cmd_fsm.sv
module pp_cmd_fsm
  import pp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cs_fall_i,
  input  logic                     cs_rise_i,
  input  logic [2:0]               bit_cnt_i,
  input  logic                     byte_valid_i,
  input  logic [7:0]               byte_i,
  input  logic                     wel_i,
  input  logic                     busy_i,
  output logic                     load_o,
  output logic [PAGE_W-1:0]        start_idx_o,
  output logic                     wr_o,
  output logic [ADDR_W-PAGE_W-1:0] page_o,
  output logic                     commit_o
);
  pp_state_e   state_q;
  logic [1:0]  acnt_q;
  logic [23:0] addr_q;
  logic [23:0] addr_nxt;
  logic        seen_q;
  logic        accept;

  assign addr_nxt = {addr_q[15:0], byte_i};
  assign accept   = (byte_i == OPC_PROG) && wel_i && !busy_i;
  assign load_o   = (state_q == ST_ADDR) && byte_valid_i && (acnt_q == 2'd2)
                    && !cs_fall_i && !cs_rise_i;
  assign start_idx_o = addr_nxt[PAGE_W-1:0];
  assign wr_o     = (state_q == ST_DATA) && byte_valid_i && !cs_fall_i && !cs_rise_i;
  assign page_o   = addr_q[ADDR_W-1:PAGE_W];
  // byte-aligned rise after at least one data byte
  assign commit_o = cs_rise_i && (state_q == ST_DATA) && seen_q
                    && (bit_cnt_i == 3'd0) && wel_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      acnt_q  <= '0;
      addr_q  <= '0;
      seen_q  <= 1'b0;
    end else if (cs_fall_i) begin
      state_q <= ST_OPC;
      acnt_q  <= '0;
      seen_q  <= 1'b0;
    end else if (cs_rise_i) begin
      state_q <= ST_IDLE;
    end else if (byte_valid_i) begin
      unique case (state_q)
        ST_OPC:  state_q <= accept ? ST_ADDR : ST_SKIP;
        ST_ADDR: begin
          addr_q <= addr_nxt;
          acnt_q <= acnt_q + 2'd1;
          if (acnt_q == 2'd2) state_q <= ST_DATA;
        end
        ST_DATA: seen_q <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pp_page_buf.sv
module pp_page_buf #(
  parameter int PAGE_W = 8,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_i,
  input  logic [PAGE_W-1:0]              start_idx_i,
  input  logic                           wr_i,
  input  logic [7:0]                     data_i,
  output logic [PAGE_BYTES-1:0][7:0]     buf_o,
  output logic [PAGE_BYTES-1:0]          valid_o
);
  logic [PAGE_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      valid_o <= '0;
      buf_o   <= '0;
    end else if (load_i) begin
      idx_q   <= start_idx_i;
      valid_o <= '0;
    end else if (wr_i) begin
      buf_o[idx_q]   <= data_i;
      valid_o[idx_q] <= 1'b1;
      idx_q          <= idx_q + 1'b1;  // wraps inside the page
    end
  end
endmodule

// File: rtl/pp_array.sv
module pp_array #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 8,
  parameter int PROG_CYCLES = 64,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int PG_W       = ADDR_W - PAGE_W,
  localparam int NUM_PAGES  = 1 << PG_W,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [PG_W-1:0]            page_i,
  input  logic [2:0]                 bp_i,
  input  logic [PAGE_BYTES-1:0][7:0] buf_i,
  input  logic [PAGE_BYTES-1:0]      valid_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [7:0]                 rd_data_o,
  output logic                       wip_o,
  output logic                       wel_clr_o
);
  logic [7:0]       mem [NUM_PAGES][PAGE_BYTES];
  logic [PG_W-1:0]  page_q;
  logic [CNT_W-1:0] cnt_q;
  logic             prot;
  logic             go;

  always_comb begin
    int n;
    n = 0;
    if (bp_i != 3'd0) n = 1 << (bp_i - 3'd1);
    if (n > NUM_PAGES) n = NUM_PAGES;
    prot = int'(page_i) >= (NUM_PAGES - n);
  end

  assign go        = commit_i && !prot;
  assign rd_data_o = mem[rd_addr_i[ADDR_W-1:PAGE_W]][rd_addr_i[PAGE_W-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wip_o     <= 1'b0;
      wel_clr_o <= 1'b0;
      cnt_q     <= '0;
      page_q    <= '0;
      for (int p = 0; p < NUM_PAGES; p++)
        for (int i = 0; i < PAGE_BYTES; i++) mem[p][i] <= 8'hFF;
    end else begin
      wel_clr_o <= go;
      if (go) begin
        wip_o  <= 1'b1;
        cnt_q  <= CNT_W'(PROG_CYCLES - 1);
        page_q <= page_i;
      end else if (wip_o) begin
        if (cnt_q == '0) begin
          wip_o <= 1'b0;
          for (int i = 0; i < PAGE_BYTES; i++)
            if (valid_i[i]) mem[page_q][i] <= mem[page_q][i] & buf_i[i];
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pp_seq.sv
module pp_seq #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 8,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic [2:0]        bit_cnt_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              wel_i,
  input  logic [2:0]        bp_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              wip_o,
  output logic              wel_clr_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;

  logic                       load;
  logic [PAGE_W-1:0]          start_idx;
  logic                       wr;
  logic [PG_W-1:0]            page;
  logic                       fsm_commit;
  logic [PAGE_BYTES-1:0][7:0] pbuf;
  logic [PAGE_BYTES-1:0]      pvalid;

  pp_cmd_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk_i, .rst_ni, .cs_fall_i, .cs_rise_i, .bit_cnt_i, .byte_valid_i, .byte_i,
    .wel_i, .busy_i(wip_o), .load_o(load), .start_idx_o(start_idx), .wr_o(wr),
    .page_o(page), .commit_o(fsm_commit)
  );

  pp_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk_i, .rst_ni, .load_i(load), .start_idx_i(start_idx), .wr_i(wr),
    .data_i(byte_i), .buf_o(pbuf), .valid_o(pvalid)
  );

  pp_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_arr (
    .clk_i, .rst_ni, .commit_i(fsm_commit), .page_i(page), .bp_i, .buf_i(pbuf),
    .valid_i(pvalid), .rd_addr_i, .rd_data_o, .wip_o, .wel_clr_o
  );
endmodule

// File: rtl/pp_seq_chk.sv
module pp_seq_chk #(
  parameter int PROG_CYCLES = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic commit_i,
  input logic wip_i,
  input logic wel_clr_i
);
  int run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 0;
    else if (wip_i) run_q <= run_q + 1;
    else run_q <= 0;
  end

  assert_wip_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_i) |-> run_q == PROG_CYCLES);

  assert_wip_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> $past(commit_i));

  assert_wel_clr_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> wel_clr_i);

  assert_wel_clr_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_i |-> wip_i);

  assert_no_commit_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !wip_i);
endmodule

bind pp_seq pp_seq_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(fsm_commit),
  .wip_i(wip_o), .wel_clr_i(wel_clr_o)
);

// File: tb/pp_seq_bench.sv
module pp_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int PAGE_W = 8;
  localparam int PROG   = 40;
  localparam int PB     = 1 << PAGE_W;
  localparam int NPG    = 1 << (ADDR_W - PAGE_W);
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_fall = 0, cs_rise = 0, bvalid = 0, wel = 1;
  logic [2:0] bit_cnt = 0, bp = 0;
  logic [7:0] bdata = 0;
  logic [ADDR_W-1:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic wip, wel_clr;

  int checks = 0, errors = 0;
  logic [7:0] mdl [DEPTH];
  logic [7:0] dat [600];

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG)) u_pp_seq (
    .clk_i(clk), .rst_ni, .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .bit_cnt_i(bit_cnt),
    .byte_valid_i(bvalid), .byte_i(bdata), .wel_i(wel), .bp_i(bp), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .wip_o(wip), .wel_clr_o(wel_clr)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit is_prot(input int page, input int lvl);
    int n;
    n = (lvl == 0) ? 0 : (1 << (lvl - 1));
    if (n > NPG) n = NPG;
    return page >= NPG - n;
  endfunction

  task automatic model_apply(input int addr, input int n);
    logic [7:0] tb_b [PB];
    bit tb_v [PB];
    int page, off;
    page = addr >> PAGE_W;
    off  = addr % PB;
    for (int i = 0; i < PB; i++) tb_v[i] = 0;
    for (int j = 0; j < n; j++) begin
      tb_b[(off + j) % PB] = dat[j];
      tb_v[(off + j) % PB] = 1;
    end
    for (int i = 0; i < PB; i++)
      if (tb_v[i]) mdl[page * PB + i] = mdl[page * PB + i] & tb_b[i];
  endtask

  task automatic compare_array(input string tag);
    int bad, first_a, first_act, first_exp;
    bad = 0; first_a = -1; first_act = 0; first_exp = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = ADDR_W'(a);
      #1;
      if (rd_data !== mdl[a]) begin
        if (bad == 0) begin first_a = a; first_act = rd_data; first_exp = mdl[a]; end
        bad++;
      end
    end
    chk(bad == 0, tag, $sformatf("array byte at %0d", first_a), first_act, first_exp);
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    bdata = b; bvalid = 1;
    @(negedge clk);
    bvalid = 0;
  endtask

  // one chip-select period; wait_done=0 returns right after the rise
  task automatic pp_cmd(input logic [7:0] opc, input int addr, input int n, input int rbit,
                        input bit busy, input bit wait_done, input string tag);
    bit exp_exec;
    int cnt;
    logic [23:0] a24;
    a24 = 24'(addr);
    exp_exec = (opc == 8'h02) && wel && !busy && (n > 0) && (rbit == 0)
               && !is_prot(addr >> PAGE_W, int'(bp));
    cs_fall = 1; @(negedge clk); cs_fall = 0;
    send_byte(opc);
    send_byte(a24[23:16]); send_byte(a24[15:8]); send_byte(a24[7:0]);
    for (int j = 0; j < n; j++) send_byte(dat[j]);
    bit_cnt = 3'(rbit); cs_rise = 1;
    @(negedge clk);
    cs_rise = 0; bit_cnt = 0;
    if (exp_exec) begin
      chk(wip === 1'b1, tag, "wip after commit (R7)", int'(wip), 1);
      chk(wel_clr === 1'b1, tag, "wel_clr pulse (R8)", int'(wel_clr), 1);
      model_apply(addr, n);
      if (wait_done) begin
        cnt = 0;
        while (wip === 1'b1 && cnt < 10 * PROG) begin cnt++; @(negedge clk); end
        chk(cnt == PROG, tag, "wip length (R7)", cnt, PROG);
        chk(wel_clr === 1'b0, tag, "wel_clr idle (R8)", int'(wel_clr), 0);
      end
    end else if (!busy) begin
      chk(wip === 1'b0, tag, "wip stays low", int'(wip), 0);
      chk(wel_clr === 1'b0, tag, "no wel_clr (R8)", int'(wel_clr), 0);
    end
  endtask

  task automatic fill(input int n);
    for (int j = 0; j < n; j++) dat[j] = 8'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int a = 0; a < DEPTH; a++) mdl[a] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(wip === 1'b0, "R11", "reset wip", int'(wip), 0);
    chk(wel_clr === 1'b0, "R11", "reset wel_clr", int'(wel_clr), 0);
    rst_ni = 1;
    @(negedge clk);
    compare_array("R11");

    // R1 R5: short write mid-page
    fill(4);
    pp_cmd(8'h02, 'h010, 4, 0, 0, 1, "R1_R5");
    compare_array("R5");

    // R2: overprogram same bytes
    fill(4);
    pp_cmd(8'h02, 'h010, 4, 0, 0, 1, "R2");
    compare_array("R2");

    // R3: write enable missing
    wel = 0; fill(8);
    pp_cmd(8'h02, 'h120, 8, 0, 0, 1, "R3");
    wel = 1;
    compare_array("R3");

    // R12: foreign opcode
    fill(8);
    pp_cmd(8'h03, 'h130, 8, 0, 0, 1, "R12");
    compare_array("R12");

    // R6: rise mid-byte, and rise right after the address
    fill(5);
    pp_cmd(8'h02, 'h140, 5, 3, 0, 1, "R6");
    pp_cmd(8'h02, 'h150, 0, 0, 0, 1, "R6");
    compare_array("R6");

    // R4: over-length write wraps within page 1
    fill(300);
    pp_cmd(8'h02, 'h1F0, 300, 0, 0, 1, "R4");
    compare_array("R4");

    // R9: level 1 protects top page only
    bp = 3'd1; fill(6);
    pp_cmd(8'h02, 'h3FC, 6, 0, 0, 1, "R9");
    compare_array("R9");
    pp_cmd(8'h02, 'h2FC, 6, 0, 0, 1, "R9");
    compare_array("R9");
    bp = 3'd2;
    pp_cmd(8'h02, 'h200, 6, 0, 0, 1, "R9");
    compare_array("R9");
    bp = 3'd0;

    // R10: second command while busy
    fill(3);
    pp_cmd(8'h02, 'h080, 3, 0, 0, 0, "R10");
    fill(3);
    pp_cmd(8'h02, 'h090, 3, 0, 1, 0, "R10");
    while (wip === 1'b1) @(negedge clk);
    compare_array("R10");

    // random mix
    for (int k = 0; k < 10; k++) begin
      int addr, len;
      addr = int'($urandom_range(DEPTH - 1, 0));
      len  = int'($urandom_range(300, 1));
      fill(len);
      pp_cmd(8'h02, addr, len, 0, 0, 1, "R4_R5");
    end
    compare_array("R2_R4");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule